// File: doc/BRIEF.md
# Clocked Transmit-Only Serial ROM Streamer

This block broadcasts the whole contents of a small byte-wide memory, one bit at a time, onto an open-drain serial data line. An external pacing clock advances the stream by one bit per rising edge. The pacing clock and a second clock line are brought into the system clock domain through two-flop synchronisers, and the edges are detected there. After power-on reset the block stays quiet for a fixed number of pacing edges to synchronise. It then sends frames of nine slots: eight data bits, most significant first, and one null slot in which the line is released. Bytes come from consecutive addresses, and the address wraps from the last location back to zero.

The memory sits outside the block and is reached through a synchronous read port. The next byte is fetched while the current frame is still going out. The starting address is not defined by the block. It is loaded from a preset input while reset is held.

A second clock line belongs to a bidirectional two-wire slave engine. While that line stays high, the block keeps streaming. A qualified falling edge on it sets a one-way mode latch. The latch releases the data line at once and grants the line to the slave engine. Only power-on reset clears the latch.

Top module: `rom_stream_tx`

## Requirements
- R1: While reset is held and right after it ends, `sda_oe_o` is 0 and `bidir_o` is 0.
- R2: For the first SYNC_CYCLES (default 9) synchronised rising edges of `pace_clk_i` after reset, `sda_oe_o` stays 0. On the next rising edge, `sda_oe_o` goes to 1 and `sda_o` carries bit 7 of the first byte.
- R3: The output changes only after a rising edge of `pace_clk_i`. A falling edge of `pace_clk_i` leaves `sda_o` and `sda_oe_o` unchanged.
- R4: Each frame takes nine pacing edges. Slots 0 to 7 drive data bits 7 down to 0 with `sda_oe_o`=1. Slot 8 is the null slot, with `sda_oe_o`=0.
- R5: Frames carry bytes from consecutive addresses. After address DEPTH-1 (127) the next frame carries address 0, with no extra slot in between.
- R6: The first frame after reset carries the byte at the address given on `start_addr_i` while reset was held.
- R7: While `host_scl_i` stays high, `bidir_o` stays 0. A qualified high-to-low transition of `host_scl_i` sets `bidir_o` to 1.
- R8: A falling edge of `host_scl_i` counts only after the synchronised line has been high for at least MIN_RUN (default 2) system clocks. A high pulse of a single system clock is ignored.
- R9: Once `bidir_o` is 1, it stays 1 regardless of `host_scl_i` or `pace_clk_i` until reset, and the stream stays frozen.
- R10: In the cycle in which the mode latch sets, `sda_oe_o` drops to 0 and stays 0 while `bidir_o` is 1.
- R11: The memory is read by a one-cycle `rd_en_o` pulse carrying `rd_addr_o`. `rd_data_i` is taken one clock later, and the byte is ready before its frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| pace_clk_i | input | 1 | Asynchronous pacing clock for the transmit-only stream |
| host_scl_i | input | 1 | Asynchronous clock line of the bidirectional slave engine |
| start_addr_i | input | ADDR_W (7) | Preset start address, loaded while reset is held |
| rd_data_i | input | DATA_W (8) | Read data from the memory, valid one clock after `rd_en_o` |
| rd_en_o | output | 1 | Memory read strobe |
| rd_addr_o | output | ADDR_W (7) | Memory read address |
| sda_o | output | 1 | Data bit presented on the line |
| sda_oe_o | output | 1 | 1 when the block drives the data line |
| bidir_o | output | 1 | Mode latch: data line granted to the bidirectional slave engine |

## Verification
The bench builds the block with its default values: a 128-byte array, 8-bit bytes, nine synchronisation edges and a two-clock high qualifier on the slave clock. With start presets of 120 and 127, the wrap from address 127 to 0 is reached within a few frames, so a run never needs a full 1161-edge pass. A reset with the slave clock held low lets a one-cycle high pulse be presented to the qualifier, and a reset with the line held high lets a handover be made in the middle of a data bit.

// File: rtl/rom_stream_pkg.sv
package rom_stream_pkg;

    typedef enum logic {
        PH_SYNC = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/rs_edge_sync.sv
module rs_edge_sync #(
    parameter bit FALLING = 1'b0,
    parameter int MIN_RUN = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic edge_o
);
    localparam int RUN_W = (MIN_RUN < 1) ? 1 : $clog2(MIN_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_RUN);
    localparam logic IDLE = FALLING;

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             s3;
        logic [RUN_W-1:0] run;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.s1   = line_i;
        d.s2   = q.s1;
        d.s3   = q.s2;
        if (q.s2 == IDLE) begin
            d.run = (q.run == RUN_MAX) ? q.run : q.run + 1'b1;
        end else begin
            d.run = '0;
        end
    end

    assign edge_o = (q.s3 == IDLE) && (q.s2 != IDLE) && (q.run == RUN_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    generate
        if (MIN_RUN >= 2) begin : g_run_chk
            // R8: a qualified edge is preceded by two synchronised idle samples
            a_r8_run_before_edge: assert property (@(posedge clk) disable iff (!rst_n)
                edge_o |-> ($past(q.s2, 2) == IDLE) && (q.s3 == IDLE));
        end
    endgenerate

endmodule

// File: rtl/rs_mode_latch.sv
module rs_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    output logic bidir_o
);
    logic mode_d, mode_q;

    always_comb begin
        mode_d = mode_q | fall_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign bidir_o = mode_q;

    a_r7_edge_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i |=> mode_q);

    a_r9_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |=> mode_q);

endmodule

// File: rtl/rs_frame_seq.sv
module rs_frame_seq
    import rom_stream_pkg::*;
#(
    parameter int DEPTH       = 128,
    parameter int DATA_W      = 8,
    parameter int SYNC_CYCLES = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step_i,
    input  logic                      halt_i,
    input  logic [$clog2(DEPTH)-1:0]  start_addr_i,
    input  logic [DATA_W-1:0]         rd_data_i,
    output logic                      rd_en_o,
    output logic [$clog2(DEPTH)-1:0]  rd_addr_o,
    output logic                      sda_o,
    output logic                      sda_oe_o
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(SYNC_CYCLES + 1);
    localparam int BIT_W  = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0]  SYNC_LAST = CNT_W'(SYNC_CYCLES);
    localparam logic [BIT_W-1:0]  NULL_IDX  = BIT_W'(DATA_W);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DATA_W - 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   sync_cnt;
        logic [BIT_W-1:0]   bit_idx;
        logic [DATA_W-1:0]  shreg;
        logic [DATA_W-1:0]  nxt;
        logic               oe;
        logic [ADDR_W-1:0]  addr;
        logic               rd_req;
        logic               pend;
    } seq_t;

    seq_t q, d;
    logic start_frame;

    always_comb begin
        d           = q;
        start_frame = 1'b0;
        d.rd_req    = 1'b0;
        d.pend      = q.rd_req;
        if (q.pend) begin
            d.nxt = rd_data_i;
        end

        if (halt_i) begin
            d.oe = 1'b0;
        end else if (step_i) begin
            if (q.ph == PH_SYNC) begin
                if (q.sync_cnt == SYNC_LAST) begin
                    start_frame = 1'b1;
                end else begin
                    d.sync_cnt = q.sync_cnt + 1'b1;
                end
            end else if (q.bit_idx == NULL_IDX) begin
                start_frame = 1'b1;
            end else begin
                d.bit_idx = q.bit_idx + 1'b1;
                if (q.bit_idx == LAST_BIT) begin
                    d.oe = 1'b0;
                end else begin
                    d.shreg = q.shreg << 1;
                end
            end
        end

        if (start_frame) begin
            d.ph      = PH_RUN;
            d.bit_idx = '0;
            d.shreg   = q.nxt;
            d.oe      = 1'b1;
            d.addr    = (q.addr == LAST_ADDR) ? '0 : q.addr + 1'b1;
            d.rd_req  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.ph     <= PH_SYNC;
            q.addr   <= start_addr_i;
            q.rd_req <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_en_o   = q.rd_req;
    assign rd_addr_o = q.addr;
    assign sda_o     = q.shreg[DATA_W-1];
    assign sda_oe_o  = q.oe;

    // R2: nothing is driven during the synchronisation period
    a_r2_quiet_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_SYNC) |-> !q.oe);

    // R4: the null slot leaves the line released
    a_r4_null_released: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_RUN && q.bit_idx == NULL_IDX) |-> !q.oe);

    // R5: a fetch that follows the last location goes to location zero
    a_r5_addr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rd_req && q.ph == PH_RUN && $past(q.addr) == LAST_ADDR) |-> (q.addr == '0));

    // R11: each fetched byte lands in the buffer one clock after the strobe
    a_r11_fetch_lands: assert property (@(posedge clk) disable iff (!rst_n)
        q.rd_req |=> q.pend);

    // R10: a halt releases the line on the next clock
    a_r10_halt_releases: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> !q.oe);

endmodule

// File: rtl/rom_stream_tx.sv
module rom_stream_tx #(
    parameter int DEPTH       = 128,
    parameter int DATA_W      = 8,
    parameter int SYNC_CYCLES = 9,
    parameter int MIN_RUN     = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pace_clk_i,
    input  logic                     host_scl_i,
    input  logic [$clog2(DEPTH)-1:0] start_addr_i,
    input  logic [DATA_W-1:0]        rd_data_i,
    output logic                     rd_en_o,
    output logic [$clog2(DEPTH)-1:0] rd_addr_o,
    output logic                     sda_o,
    output logic                     sda_oe_o,
    output logic                     bidir_o
);
    logic pace_rise;
    logic host_fall;
    logic mode_q;
    logic seq_oe;

    rs_edge_sync #(.FALLING(1'b0), .MIN_RUN(1)) u_pace_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (pace_clk_i),
        .edge_o (pace_rise)
    );

    rs_edge_sync #(.FALLING(1'b1), .MIN_RUN(MIN_RUN)) u_host_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (host_scl_i),
        .edge_o (host_fall)
    );

    rs_mode_latch u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (host_fall),
        .bidir_o (mode_q)
    );

    rs_frame_seq #(
        .DEPTH       (DEPTH),
        .DATA_W      (DATA_W),
        .SYNC_CYCLES (SYNC_CYCLES)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_i       (pace_rise),
        .halt_i       (mode_q),
        .start_addr_i (start_addr_i),
        .rd_data_i    (rd_data_i),
        .rd_en_o      (rd_en_o),
        .rd_addr_o    (rd_addr_o),
        .sda_o        (sda_o),
        .sda_oe_o     (seq_oe)
    );

    assign sda_oe_o = seq_oe & ~mode_q;
    assign bidir_o  = mode_q;

endmodule

// File: tb/tb_rom_stream_tx.sv
module tb_rom_stream_tx;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 128;
    localparam int DATA_W = 8;
    localparam int SYNC   = 9;
    localparam int AW     = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pace = 1'b0;
    logic host = 1'b1;
    logic [AW-1:0] start_addr = '0;
    logic [DATA_W-1:0] rd_data = '0;
    logic rd_en;
    logic [AW-1:0] rd_addr;
    logic sda, sda_oe, bidir;

    always #(CLK_PERIOD/2) clk = ~clk;

    rom_stream_tx dut (
        .clk(clk), .rst_n(rst_n), .pace_clk_i(pace), .host_scl_i(host),
        .start_addr_i(start_addr), .rd_data_i(rd_data), .rd_en_o(rd_en),
        .rd_addr_o(rd_addr), .sda_o(sda), .sda_oe_o(sda_oe), .bidir_o(bidir)
    );

    logic [DATA_W-1:0] mem [DEPTH];
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    typedef struct { logic oe; logic val; string tag; } exp_t;
    exp_t exp_q[$];

    int checks = 0;
    int fails = 0;
    int rise_n = 0;
    int base = 0;
    bit frozen = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic exp_t model(input int n);
        exp_t e;
        e.oe = 1'b0; e.val = 1'b0;
        if (frozen) begin
            e.tag = "R9 R10 frozen after handover";
        end else if (n <= SYNC) begin
            e.tag = "R2 sync quiet";
        end else begin
            int k  = n - SYNC - 1;
            int fr = k / 9;
            int b  = k % 9;
            int a  = (base + fr) % DEPTH;
            if (b == 8) begin
                e.tag = "R4 null slot";
            end else begin
                e.oe  = 1'b1;
                e.val = mem[a][7-b];
                e.tag = (n == SYNC + 1) ? "R2 R6 first MSB" : "R4 R5 R11 data bit";
            end
        end
        return e;
    endfunction

    task automatic do_reset(input int st, input logic host_lvl);
        rst_n = 1'b0; pace = 1'b0; host = host_lvl;
        start_addr = AW'(st);
        base = st; rise_n = 0; frozen = 1'b0;
        repeat (5) @(negedge clk);
        check(sda_oe == 1'b0 && bidir == 1'b0, "R1 in reset", {sda_oe, bidir}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(sda_oe == 1'b0 && bidir == 1'b0, "R1 after reset", {sda_oe, bidir}, 0);
    endtask

    task automatic drive_rise();
        rise_n++;
        exp_q.push_back(model(rise_n));
        pace = 1'b1;
        repeat (6) @(negedge clk);
        pace = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic rises(input int n);
        for (int i = 0; i < n; i++) drive_rise();
    endtask

    // monitor: pops one expectation per pacing edge and compares twice
    initial begin
        forever begin
            exp_t e;
            logic [1:0] act, expv;
            @(posedge pace);
            e = exp_q.pop_front();
            expv = {e.oe, e.oe & e.val};
            repeat (4) @(negedge clk);
            act = {sda_oe, sda_oe & sda};
            check(act == expv, e.tag, act, expv);
            @(negedge pace);
            repeat (5) @(negedge clk);
            act = {sda_oe, sda_oe & sda};
            check(act == expv, "R3 stable after falling pace edge", act, expv);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'((i * 73 + 19) ^ (i >> 2));

        // run 1: start near the top, slave clock high, wrap through 127 -> 0
        do_reset(120, 1'b1);
        rises(SYNC + 12 * 9);
        check(bidir == 1'b0, "R7 stays transmit while line high", bidir, 0);
        drive_rise();                 // slot 0 of a frame, line driven
        check(sda_oe == 1'b1, "R10 driving before handover", sda_oe, 1);
        host = 1'b0;
        repeat (6) @(negedge clk);
        check(bidir == 1'b1, "R7 falling edge hands over", bidir, 1);
        check(sda_oe == 1'b0, "R10 line released on handover", sda_oe, 0);
        frozen = 1'b1;
        for (int i = 0; i < 3; i++) begin
            host = 1'b1; repeat (4) @(negedge clk);
            host = 1'b0; repeat (4) @(negedge clk);
            drive_rise();
        end
        check(bidir == 1'b1, "R9 latch sticky", bidir, 1);

        // run 2: start at 0, slave clock low at reset, short pulse ignored
        do_reset(0, 1'b0);
        repeat (4) @(negedge clk);
        host = 1'b1; @(negedge clk); host = 1'b0;
        repeat (6) @(negedge clk);
        check(bidir == 1'b0, "R8 one-cycle pulse ignored", bidir, 0);
        rises(SYNC + 3 * 9);
        host = 1'b1; repeat (4) @(negedge clk);
        check(bidir == 1'b0, "R7 high line keeps transmit", bidir, 0);
        host = 1'b0; repeat (6) @(negedge clk);
        check(bidir == 1'b1, "R8 qualified edge accepted", bidir, 1);
        frozen = 1'b1;
        drive_rise();

        // run 3: start at the last location, wrap on the first frame
        do_reset(DEPTH - 1, 1'b1);
        rises(SYNC + 3 * 9);
        check(bidir == 1'b0, "R1 reset cleared the mode latch", bidir, 0);

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule